// File: doc/BRIEF.md
# Immediate and Absolute Load Sequencer

This block carries out the memory side of five byte and word load instructions. When a start is accepted it reads operand bytes at the program counter and data bytes from memory, or writes the accumulator to memory, over a byte-wide port. Every read byte is handed back on a register write-back strobe together with a destination index. The block advances its own program counter past the operand bytes, adds three clock states to a running cycle counter after each single byte access, and maintains the hidden 16-bit WZ helper register the way the processor does.

Opcode decode and fetch sit outside the block. The decoder presents the load kind, a register or pair selector, the current BC pair and the accumulator, and pulses start. Memory is combinational: read data must be valid in the same cycle as the read strobe. Every byte access takes exactly one clock of the block, and multi-byte values always move low byte first.

Top module: `ldseq_top`

## Requirements
- R1: After reset, busy, done, both strobes and write-back enable are low, and the program counter, WZ and the cycle counter are all zero.
- R2: Kind 0 (byte immediate) reads one byte at the program counter, returns it on write-back with index equal to the 3-bit selector, and leaves the program counter one higher.
- R3: Kind 1 (word immediate) reads at PC then PC+1; the first byte goes to the low half and the second to the high half of the pair chosen by selector bits 1:0 (0 = BC, 1 = DE, 2 = HL, 3 = SP). Write-back indices are 2p for a high half and 2p+1 for a low half for pairs 0 to 2, and 8 (high) and 9 (low) for SP. The program counter advances by two.
- R4: Kind 2 reads one byte at the address on the BC input, returns it with index 7 (accumulator), sets WZ to BC+1 (modulo 2^16) and leaves the program counter unchanged.
- R5: Kind 3 (pair from absolute address) makes four reads in this order: address low at PC, address high at PC+1, data low at the address, data high at the address plus one; the data bytes go to the selected pair as in R3, WZ becomes the address plus one, and the program counter advances by two.
- R6: Kind 4 (accumulator to absolute address) reads the address low and high bytes at PC and PC+1, then writes the accumulator value captured at start to that address in one write cycle; WZ becomes the accumulator in the high byte and the address low byte plus one (modulo 256) in the low byte.
- R7: Each byte access occupies one clock and adds exactly 3 to the cycle counter; an instruction of n accesses adds 3n. The counter does not move in cycles without an access.
- R8: Busy is high from the cycle after an accepted start until the last access; done is a single-cycle pulse in the cycle right after the last access.
- R9: A start while busy has no effect on the running sequence, and a start with kind 5, 6 or 7 is ignored entirely: no access, no counter or program counter change.
- R10: The read and write strobes are never high together, and neither is high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a load sequence |
| kind_i | input | 3 | Load kind, 0 to 4 valid |
| sel_i | input | 3 | Register index (kind 0) or pair in bits 1:0 (kinds 1, 3) |
| bc_i | input | 16 | Current BC pair, used by kind 2 |
| acc_i | input | 8 | Current accumulator, used by kind 4 |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with the read strobe |
| wb_en_o | output | 1 | Register write-back enable |
| wb_idx_o | output | 4 | Register write-back index |
| wb_data_o | output | 8 | Register write-back byte |
| pc_o | output | 16 | Program counter |
| wz_o | output | 16 | Hidden WZ register |
| tstates_o | output | 32 | Running clock-state counter |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A corrupted sequencer state shows up at once at the memory port: a skipped or repeated step changes the address sequence, the number of strobes and the length of busy within the same instruction, and the bench compares all three against counts derived per kind. A latched address byte in the wrong half surfaces as a wrong data address or a wrong WZ on the very next access. Drift in the program counter or the cycle counter stays visible on the ports and is caught at the end of the instruction that caused it, since each instruction checks the absolute values.

// File: rtl/ldseq_pkg.sv
package ldseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OP_LO  = 3'd1,
        ST_OP_HI  = 3'd2,
        ST_DAT_LO = 3'd3,
        ST_DAT_HI = 3'd4
    } ldseq_state_e;

    typedef enum logic [1:0] {
        PART_SINGLE = 2'd0,
        PART_LO     = 2'd1,
        PART_HI     = 2'd2
    } ldseq_part_e;

    localparam logic [2:0] KIND_IMM8   = 3'd0;
    localparam logic [2:0] KIND_IMM16  = 3'd1;
    localparam logic [2:0] KIND_IND_BC = 3'd2;
    localparam logic [2:0] KIND_ABS16  = 3'd3;
    localparam logic [2:0] KIND_STA    = 3'd4;

    localparam logic [2:0] REG_ACC     = 3'd7;

endpackage

// File: rtl/ldseq_wb_map.sv
module ldseq_wb_map
    import ldseq_pkg::*;
#(
    parameter int SELW = 3,
    parameter int IDXW = 4
) (
    input  logic [SELW-1:0] sel_i,
    input  ldseq_part_e     part_i,
    output logic [IDXW-1:0] idx_o
);
    localparam logic [IDXW-1:0] SP_HI_IDX = IDXW'(8);
    localparam logic [IDXW-1:0] SP_LO_IDX = IDXW'(9);

    logic [1:0] pair;
    logic       is_sp;

    assign pair  = sel_i[1:0];
    assign is_sp = (pair == 2'd3);

    always_comb begin
        unique case (part_i)
            PART_LO:  idx_o = is_sp ? SP_LO_IDX : IDXW'({pair, 1'b1});
            PART_HI:  idx_o = is_sp ? SP_HI_IDX : IDXW'({pair, 1'b0});
            default:  idx_o = IDXW'(sel_i);
        endcase
    end
endmodule

// File: rtl/ldseq_tcount.sv
module ldseq_tcount #(
    parameter int TW   = 32,
    parameter int STEP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          access_i,
    output logic [TW-1:0] count_o
);
    localparam logic [TW-1:0] STEP_V = TW'(STEP);

    logic [TW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (access_i) count_d = count_q + STEP_V;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        access_i |=> (count_q == $past(count_q) + STEP_V));
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !access_i |=> $stable(count_q));
endmodule

// File: rtl/ldseq_ctrl.sv
module ldseq_ctrl
    import ldseq_pkg::*;
#(
    parameter int DW   = 8,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [2:0]      kind_i,
    input  logic [SELW-1:0] sel_i,
    input  logic [2*DW-1:0] bc_i,
    input  logic [DW-1:0]   acc_i,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic [2*DW-1:0] mem_addr_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic [DW-1:0]   mem_wdata_o,
    output logic            wb_en_o,
    output ldseq_part_e     wb_part_o,
    output logic [SELW-1:0] wb_sel_o,
    output logic [DW-1:0]   wb_data_o,
    output logic [2*DW-1:0] pc_o,
    output logic [2*DW-1:0] wz_o,
    output logic            busy_o,
    output logic            done_o
);
    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] ONE_W = AW'(1);
    localparam logic [DW-1:0] ONE_B = DW'(1);

    typedef struct packed {
        ldseq_state_e    st;
        logic [2:0]      kind;
        logic [SELW-1:0] sel;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   acc;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   wz;
        logic            done;
    } ctrl_s;

    ctrl_s q, d;
    logic  kind_ok;

    assign kind_ok = (kind_i <= KIND_STA);

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        mem_addr_o  = q.pc;
        mem_rd_o    = 1'b0;
        mem_wr_o    = 1'b0;
        mem_wdata_o = '0;
        wb_en_o     = 1'b0;
        wb_part_o   = PART_SINGLE;

        unique case (q.st)
            ST_IDLE: begin
                if (start_i && kind_ok) begin
                    d.kind = kind_i;
                    d.sel  = sel_i;
                    d.acc  = acc_i;
                    if (kind_i == KIND_IND_BC) begin
                        d.addr = bc_i;
                        d.sel  = SELW'(REG_ACC);
                        d.st   = ST_DAT_LO;
                    end else begin
                        d.st   = ST_OP_LO;
                    end
                end
            end

            ST_OP_LO: begin
                mem_addr_o = q.pc;
                mem_rd_o   = 1'b1;
                d.pc       = q.pc + ONE_W;
                if (q.kind == KIND_IMM8) begin
                    wb_en_o   = 1'b1;
                    wb_part_o = PART_SINGLE;
                    d.st      = ST_IDLE;
                    d.done    = 1'b1;
                end else if (q.kind == KIND_IMM16) begin
                    wb_en_o   = 1'b1;
                    wb_part_o = PART_LO;
                    d.st      = ST_OP_HI;
                end else begin
                    d.addr[DW-1:0] = mem_rdata_i;
                    d.st           = ST_OP_HI;
                end
            end

            ST_OP_HI: begin
                mem_addr_o = q.pc;
                mem_rd_o   = 1'b1;
                d.pc       = q.pc + ONE_W;
                if (q.kind == KIND_IMM16) begin
                    wb_en_o   = 1'b1;
                    wb_part_o = PART_HI;
                    d.st      = ST_IDLE;
                    d.done    = 1'b1;
                end else begin
                    d.addr[AW-1:DW] = mem_rdata_i;
                    d.st            = ST_DAT_LO;
                end
            end

            ST_DAT_LO: begin
                mem_addr_o = q.addr;
                if (q.kind == KIND_STA) begin
                    mem_wr_o    = 1'b1;
                    mem_wdata_o = q.acc;
                    d.wz        = {q.acc, q.addr[DW-1:0] + ONE_B};
                    d.st        = ST_IDLE;
                    d.done      = 1'b1;
                end else if (q.kind == KIND_IND_BC) begin
                    mem_rd_o  = 1'b1;
                    wb_en_o   = 1'b1;
                    wb_part_o = PART_SINGLE;
                    d.wz      = q.addr + ONE_W;
                    d.st      = ST_IDLE;
                    d.done    = 1'b1;
                end else begin
                    mem_rd_o  = 1'b1;
                    wb_en_o   = 1'b1;
                    wb_part_o = PART_LO;
                    d.st      = ST_DAT_HI;
                end
            end

            ST_DAT_HI: begin
                mem_addr_o = q.addr + ONE_W;
                mem_rd_o   = 1'b1;
                wb_en_o    = 1'b1;
                wb_part_o  = PART_HI;
                d.wz       = q.addr + ONE_W;
                d.st       = ST_IDLE;
                d.done     = 1'b1;
            end

            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.kind <= '0;
            q.sel  <= '0;
            q.addr <= '0;
            q.acc  <= '0;
            q.pc   <= '0;
            q.wz   <= '0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign wb_sel_o  = q.sel;
    assign wb_data_o = mem_rdata_i;
    assign pc_o      = q.pc;
    assign wz_o      = q.wz;
    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = q.done;

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(mem_rd_o || mem_wr_o));
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(q.kind) && $stable(q.acc));
    assert_bad_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !kind_ok) |=> !busy_o);
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.pc) |-> (q.pc == $past(q.pc) + ONE_W));
endmodule

// File: rtl/ldseq_top.sv
module ldseq_top
    import ldseq_pkg::*;
#(
    parameter int DW   = 8,
    parameter int TW   = 32,
    parameter int STEP = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [2:0]      kind_i,
    input  logic [2:0]      sel_i,
    input  logic [2*DW-1:0] bc_i,
    input  logic [DW-1:0]   acc_i,
    output logic [2*DW-1:0] mem_addr_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic            wb_en_o,
    output logic [3:0]      wb_idx_o,
    output logic [DW-1:0]   wb_data_o,
    output logic [2*DW-1:0] pc_o,
    output logic [2*DW-1:0] wz_o,
    output logic [TW-1:0]   tstates_o,
    output logic            busy_o,
    output logic            done_o
);
    localparam int SELW = 3;
    localparam int IDXW = 4;

    ldseq_part_e     part;
    logic [SELW-1:0] wsel;

    ldseq_ctrl #(.DW(DW), .SELW(SELW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .kind_i      (kind_i),
        .sel_i       (sel_i),
        .bc_i        (bc_i),
        .acc_i       (acc_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_addr_o  (mem_addr_o),
        .mem_rd_o    (mem_rd_o),
        .mem_wr_o    (mem_wr_o),
        .mem_wdata_o (mem_wdata_o),
        .wb_en_o     (wb_en_o),
        .wb_part_o   (part),
        .wb_sel_o    (wsel),
        .wb_data_o   (wb_data_o),
        .pc_o        (pc_o),
        .wz_o        (wz_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    ldseq_wb_map #(.SELW(SELW), .IDXW(IDXW)) u_map (
        .sel_i  (wsel),
        .part_i (part),
        .idx_o  (wb_idx_o)
    );

    ldseq_tcount #(.TW(TW), .STEP(STEP)) u_tcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .access_i (mem_rd_o || mem_wr_o),
        .count_o  (tstates_o)
    );
endmodule

// File: tb/tb_ldseq_top.sv
module tb_ldseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  kind_i = '0;
    logic [2:0]  sel_i = '0;
    logic [15:0] bc_i = '0;
    logic [7:0]  acc_i = '0;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o, mem_wr_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;
    logic        wb_en_o;
    logic [3:0]  wb_idx_o;
    logic [7:0]  wb_data_o;
    logic [15:0] pc_o, wz_o;
    logic [31:0] tstates_o;
    logic        busy_o, done_o;

    always #2 clk = ~clk;

    ldseq_top dut (.*);

    int checks = 0;
    int fails  = 0;

    logic        ov_en = 1'b0;
    logic [15:0] ov_a0 = '0, ov_a1 = '0;
    logic [7:0]  ov_d0 = '0, ov_d1 = '0;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return (a[7:0] ^ {a[14:8], a[15]}) + 8'h3C;
    endfunction

    assign mem_rdata_i = (ov_en && mem_addr_o == ov_a0) ? ov_d0 :
                         (ov_en && mem_addr_o == ov_a1) ? ov_d1 : pat(mem_addr_o);

    // port activity log, sampled away from the active edge
    logic [3:0]  ev_idx [0:7];
    logic [7:0]  ev_dat [0:7];
    int          n_ev = 0, n_wr = 0, n_acc = 0;
    logic [15:0] wr_a;
    logic [7:0]  wr_d;

    always @(negedge clk) begin
        if (mem_rd_o || mem_wr_o) n_acc++;
        if (wb_en_o && n_ev < 8) begin
            ev_idx[n_ev] = wb_idx_o;
            ev_dat[n_ev] = wb_data_o;
            n_ev++;
        end
        if (mem_wr_o) begin
            wr_a = mem_addr_o;
            wr_d = mem_wdata_o;
            n_wr++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    logic [15:0] pc_exp = '0, wz_exp = '0;
    logic [31:0] t_exp = '0;

    function automatic logic [3:0] lo_idx(input logic [1:0] p);
        return (p == 2'd3) ? 4'd9 : {1'b0, p, 1'b1};
    endfunction
    function automatic logic [3:0] hi_idx(input logic [1:0] p);
        return (p == 2'd3) ? 4'd8 : {1'b0, p, 1'b0};
    endfunction

    task automatic do_op(input logic [2:0] kind, input logic [2:0] sel,
                         input logic [15:0] bc, input logic [7:0] acc,
                         input logic [15:0] nn, input bit inject, input string req);
        int          acc_n, n_exp_ev, cnt;
        logic [3:0]  e_idx [0:1];
        logic [7:0]  e_dat [0:1];
        logic [15:0] pc0;
        pc0 = pc_exp;
        ov_en = (kind == 3'd3 || kind == 3'd4);
        ov_a0 = pc0; ov_d0 = nn[7:0];
        ov_a1 = pc0 + 16'd1; ov_d1 = nn[15:8];
        n_exp_ev = 0;
        case (kind)
            3'd0: begin acc_n = 1; n_exp_ev = 1; e_idx[0] = {1'b0, sel}; e_dat[0] = pat(pc0);
                        pc_exp = pc0 + 16'd1; end
            3'd1: begin acc_n = 2; n_exp_ev = 2;
                        e_idx[0] = lo_idx(sel[1:0]); e_dat[0] = pat(pc0);
                        e_idx[1] = hi_idx(sel[1:0]); e_dat[1] = pat(pc0 + 16'd1);
                        pc_exp = pc0 + 16'd2; end
            3'd2: begin acc_n = 1; n_exp_ev = 1; e_idx[0] = 4'd7; e_dat[0] = pat(bc);
                        wz_exp = bc + 16'd1; end
            3'd3: begin acc_n = 4; n_exp_ev = 2;
                        e_idx[0] = lo_idx(sel[1:0]); e_dat[0] = pat(nn);
                        e_idx[1] = hi_idx(sel[1:0]); e_dat[1] = pat(nn + 16'd1);
                        pc_exp = pc0 + 16'd2; wz_exp = nn + 16'd1; end
            default: begin acc_n = 3; pc_exp = pc0 + 16'd2;
                        wz_exp = {acc, nn[7:0] + 8'd1}; end
        endcase
        t_exp = t_exp + 32'(3 * acc_n);
        n_ev = 0; n_wr = 0; n_acc = 0;
        kind_i = kind; sel_i = sel; bc_i = bc; acc_i = acc; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cnt = 0;
        while (!done_o && cnt < 20) begin
            if (inject && cnt == 1) begin
                start_i = 1'b1; kind_i = 3'd0; acc_i = ~acc;
            end else begin
                start_i = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(cnt == acc_n, "R8", "busy length", 32'(cnt), 32'(acc_n));
        chk(n_acc == acc_n, req, "access count", 32'(n_acc), 32'(acc_n));
        chk(n_ev == n_exp_ev, req, "writeback count", 32'(n_ev), 32'(n_exp_ev));
        for (int i = 0; i < n_exp_ev && i < n_ev; i++) begin
            chk(ev_idx[i] == e_idx[i], req, "writeback index", 32'(ev_idx[i]), 32'(e_idx[i]));
            chk(ev_dat[i] == e_dat[i], req, "writeback data", 32'(ev_dat[i]), 32'(e_dat[i]));
        end
        if (kind == 3'd4) begin
            chk(n_wr == 1, "R6", "write count", 32'(n_wr), 32'd1);
            chk(wr_a == nn, "R6", "write address", 32'(wr_a), 32'(nn));
            chk(wr_d == acc, "R6", "write data", 32'(wr_d), 32'(acc));
        end else begin
            chk(n_wr == 0, "R10", "no write on load", 32'(n_wr), 32'd0);
        end
        chk(pc_o == pc_exp, req, "program counter", 32'(pc_o), 32'(pc_exp));
        chk(wz_o == wz_exp, req, "WZ", 32'(wz_o), 32'(wz_exp));
        chk(tstates_o == t_exp, "R7", "clock states", tstates_o, t_exp);
        @(negedge clk);
        chk(!done_o, "R8", "done single cycle", 32'(done_o), 32'd0);
        chk(!busy_o, "R9", "no restart after done", 32'(busy_o), 32'd0);
        ov_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o, "R1", "busy/done", {30'd0, busy_o, done_o}, 32'd0);
        chk(!mem_rd_o && !mem_wr_o && !wb_en_o, "R1", "strobes",
            {29'd0, mem_rd_o, mem_wr_o, wb_en_o}, 32'd0);
        chk(pc_o == 0 && wz_o == 0 && tstates_o == 0, "R1", "pc/wz/count",
            32'(pc_o) | 32'(wz_o) | tstates_o, 32'd0);

        // R2: every register index
        for (int s = 0; s < 8; s++) do_op(3'd0, 3'(s), 16'h0, 8'h0, 16'h0, 1'b0, "R2");
        // R3: every pair
        for (int p = 0; p < 4; p++) do_op(3'd1, 3'(p), 16'h0, 8'h0, 16'h0, 1'b0, "R3");
        // R4: BC indirect, including wrap of BC+1
        do_op(3'd2, 3'd0, 16'h1234, 8'h0, 16'h0, 1'b0, "R4");
        do_op(3'd2, 3'd0, 16'hFFFF, 8'h0, 16'h0, 1'b0, "R4");
        do_op(3'd2, 3'd0, 16'h0000, 8'h0, 16'h0, 1'b0, "R4");
        // R5: absolute pair load, page crossing and full wrap
        do_op(3'd3, 3'd2, 16'h0, 8'h0, 16'h4000, 1'b0, "R5");
        do_op(3'd3, 3'd3, 16'h0, 8'h0, 16'hFFFF, 1'b0, "R5");
        do_op(3'd3, 3'd1, 16'h0, 8'h0, 16'h80FF, 1'b0, "R5");
        // R6: accumulator store, low byte wrap for WZ
        do_op(3'd4, 3'd0, 16'h0, 8'hA5, 16'h12FF, 1'b0, "R6");
        do_op(3'd4, 3'd0, 16'h0, 8'h3C, 16'h3456, 1'b0, "R6");
        do_op(3'd4, 3'd0, 16'h0, 8'h00, 16'hFFFF, 1'b0, "R6");
        // R9: start during a running sequence is ignored
        do_op(3'd3, 3'd0, 16'h0, 8'h11, 16'h5AA5, 1'b1, "R9");
        do_op(3'd4, 3'd0, 16'h0, 8'h77, 16'h2001, 1'b1, "R9");

        // R9: invalid kinds are ignored
        for (int k = 5; k < 8; k++) begin
            n_acc = 0;
            kind_i = 3'(k); start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (3) @(negedge clk);
            chk(n_acc == 0, "R9", "invalid kind access", 32'(n_acc), 32'd0);
            chk(!busy_o, "R9", "invalid kind busy", 32'(busy_o), 32'd0);
            chk(tstates_o == t_exp && pc_o == pc_exp, "R9", "invalid kind state",
                tstates_o, t_exp);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule